// File: doc/BRIEF.md
# Pin Change Interrupt Controller

This block watches a small group of general-purpose input pins and raises one shared interrupt request whenever any selected pin changes level, rising or falling. Each pin is first brought into the clock domain by a synchronizer. A change is found by comparing the synchronized level with its value one clock earlier. Any change on a pin whose select bit is set latches a single group flag.

Software uses three byte-wide registers on a simple processor I/O bus. A pin-select register at 0x10 holds one enable bit per pin in bits 3:0. A flag register at 0x11 holds the group flag in bit 0. A control register at 0x12 holds the group enable in bit 0. All unused bits read as zero. The request output is a level. It is active while the flag, the group enable and the CPU's global interrupt bit are all set. The flag clears when the core acknowledges the interrupt, or when software writes a one to flag bit 0.

Bus reads have one cycle of latency. `bus_rdata_o` is registered at the rising edge from the address presented before that edge. The request output is also registered, one edge after its three terms.

Top module: `pinchg_irq_ctrl`

## Requirements
- R1: After reset, the registers at 0x10, 0x11 and 0x12 all read 0x00 and `irq_o` is 0.
- R2: The pin-select register (0x10) stores bits 3:0 of a write and reads bits 7:4 as zero. The control register (0x12) stores bit 0 of a write and reads bits 7:1 as zero.
- R3: A rising or a falling level change on a pin whose select bit is 1 sets the group flag (bit 0 of 0x11) to 1.
- R4: A level change on a pin whose select bit is 0 leaves the group flag unchanged.
- R5: At each rising edge, `irq_o` takes the value of (flag AND group enable (0x12 bit 0) AND `gie_i`) as they stood before that edge.
- R6: A one-cycle pulse on `irq_ack_i` clears the group flag.
- R7: Writing a value with bit 0 = 1 to 0x11 clears the flag. Writing a value with bit 0 = 0 to 0x11 leaves the flag unchanged.
- R8: When a qualifying pin change is detected in the same cycle as a clear (acknowledge or write-one), the flag is 1 afterwards.
- R9: Reads of any address other than 0x10, 0x11 and 0x12 return 0x00. Writes to such addresses change no register.
- R10: With the enables set, a pin change driven between edges makes `irq_o` 1 after the fourth following rising edge and not after the third. The four edges are two synchronizer stages, the flag register and the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 4 | Raw asynchronous pin levels |
| gie_i | input | 1 | Global interrupt enable from the CPU status register |
| irq_ack_i | input | 1 | One-cycle strobe: the interrupt is being serviced |
| bus_addr_i | input | 6 | I/O register address |
| bus_wdata_i | input | 8 | Write data |
| bus_we_i | input | 1 | Write strobe |
| bus_rdata_o | output | 8 | Registered read data for the address seen at the last edge |
| irq_o | output | 1 | Level interrupt request |

## Verification
Pins are toggled in both directions, with and without their select bits, to tell a true change detector apart from a rising-only detector and from one that ignores the mask. The output gate is tried with each enable term cleared in turn. The flag clear is tried with write-zero, write-one, acknowledge and writes to unmapped addresses. A pin change is timed to land in the same cycle as a clear, which separates set-priority from clear-priority. A cycle-exact check of the request's arrival exposes a missing or an extra synchronizer stage.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int FLAG_BIT = 0;
  localparam int EN_BIT   = 0;

endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stg_q;
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= din;
      end
      assign dout = stg_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stg_q;
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= {stg_q[STAGES-2:0], din};
      end
      assign dout = stg_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/pinchg_edge_det.sv
module pinchg_edge_det #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] sel_i,
  output logic             any_chg_o
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] chg;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign chg[i] = (level_i[i] ^ prev_q[i]) & sel_i[i];
  end

  assign any_chg_o = |chg;

endmodule

// File: rtl/pinchg_regs.sv
module pinchg_regs
  import pinchg_pkg::*;
#(
  parameter int              NUM_PINS  = 4,
  parameter int              ADDR_W    = 6,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h11,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                we_i,
  input  logic                any_chg_i,
  input  logic                ack_i,
  output logic [NUM_PINS-1:0] mask_o,
  output logic                en_o,
  output logic                flag_o,
  output logic [DATA_W-1:0]   rdata_o
);

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] mask_q;
  logic                en_q;
  logic                flag_q;
  logic                sw_clr;
  logic [DATA_W-1:0]   rdata_d;
  logic [DATA_W-1:0]   rdata_q;
  logic                wdata_unused;

  assign wdata_unused = ^wdata_i;

  always_comb begin
    if      (addr_i == MASK_ADDR) sel = SEL_MASK;
    else if (addr_i == FLAG_ADDR) sel = SEL_FLAG;
    else if (addr_i == CTRL_ADDR) sel = SEL_CTRL;
    else                          sel = SEL_NONE;
  end

  assign sw_clr = we_i && (sel == SEL_FLAG) && wdata_i[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst)                            mask_q <= '0;
    else if (we_i && sel == SEL_MASK)   mask_q <= wdata_i[NUM_PINS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                            en_q <= 1'b0;
    else if (we_i && sel == SEL_CTRL)   en_q <= wdata_i[EN_BIT];
  end

  // set has priority over both clear sources
  always_ff @(posedge clk) begin
    if (rst)                    flag_q <= 1'b0;
    else if (any_chg_i)         flag_q <= 1'b1;
    else if (ack_i || sw_clr)   flag_q <= 1'b0;
  end

  always_comb begin
    rdata_d = '0;
    unique case (sel)
      SEL_MASK: rdata_d[NUM_PINS-1:0] = mask_q;
      SEL_FLAG: rdata_d[FLAG_BIT]     = flag_q;
      SEL_CTRL: rdata_d[EN_BIT]       = en_q;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  assign mask_o  = mask_q;
  assign en_o    = en_q;
  assign flag_o  = flag_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/pinchg_irq_ctrl.sv
module pinchg_irq_ctrl #(
  parameter int                NUM_PINS    = 4,
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 6,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 'h10,
  parameter logic [ADDR_W-1:0] FLAG_ADDR   = 'h11,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                gie_i,
  input  logic                irq_ack_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  input  logic                bus_we_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] mask_w;
  logic                any_chg_w;
  logic                en_w;
  logic                flag_w;
  logic                irq_q;

  pinchg_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pins_i),
    .dout (pin_sync)
  );

  pinchg_edge_det #(
    .WIDTH (NUM_PINS)
  ) u_edge (
    .clk       (clk),
    .rst       (rst),
    .level_i   (pin_sync),
    .sel_i     (mask_w),
    .any_chg_o (any_chg_w)
  );

  pinchg_regs #(
    .NUM_PINS  (NUM_PINS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MASK_ADDR (MASK_ADDR),
    .FLAG_ADDR (FLAG_ADDR),
    .CTRL_ADDR (CTRL_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .we_i      (bus_we_i),
    .any_chg_i (any_chg_w),
    .ack_i     (irq_ack_i),
    .mask_o    (mask_w),
    .en_o      (en_w),
    .flag_o    (flag_w),
    .rdata_o   (bus_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= flag_w & en_w & gie_i;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/pinchg_irq_chk.sv
module pinchg_irq_chk #(
  parameter int                ADDR_W    = 6,
  parameter int                DATA_W    = 8,
  parameter int                NUM_PINS  = 4,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 'h11,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h12
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              we,
  input logic              ack,
  input logic              gie,
  input logic              any_chg,
  input logic              flag_q,
  input logic              en_q,
  input logic              irq,
  input logic [DATA_W-1:0] rdata
);

  logic unmapped;
  assign unmapped = (addr != MASK_ADDR) && (addr != FLAG_ADDR) && (addr != CTRL_ADDR);

  assert_irq_on_R5: assert property (@(posedge clk) disable iff (rst)
    (flag_q && en_q && gie) |=> irq);

  assert_irq_off_R5: assert property (@(posedge clk) disable iff (rst)
    !(flag_q && en_q && gie) |=> !irq);

  assert_set_R3: assert property (@(posedge clk) disable iff (rst)
    any_chg |=> flag_q);

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (ack && !any_chg) |=> !flag_q);

  assert_wr0_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (we && addr == FLAG_ADDR && !wdata[0] && !ack && !any_chg) |=> $stable(flag_q));

  assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
    (addr == CTRL_ADDR) |=> (rdata[DATA_W-1:1] == '0));

  assert_mask_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
    (addr == MASK_ADDR) |=> (rdata[DATA_W-1:NUM_PINS] == '0));

  assert_unmapped_R9: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> (rdata == '0));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (any_chg && (ack || (we && addr == FLAG_ADDR && wdata[0]))) |=> flag_q);

endmodule

bind pinchg_irq_ctrl pinchg_irq_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_PINS  (NUM_PINS),
  .MASK_ADDR (MASK_ADDR),
  .FLAG_ADDR (FLAG_ADDR),
  .CTRL_ADDR (CTRL_ADDR)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .addr    (bus_addr_i),
  .wdata   (bus_wdata_i),
  .we      (bus_we_i),
  .ack     (irq_ack_i),
  .gie     (gie_i),
  .any_chg (any_chg_w),
  .flag_q  (flag_w),
  .en_q    (en_w),
  .irq     (irq_o),
  .rdata   (bus_rdata_o)
);

// File: tb/pinchg_irq_ctrl_tb.sv
module pinchg_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] pins = '0;
  logic       gie = 1'b0;
  logic       ack = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_strobe = 1'b0;
  logic       rd_seen = 1'b0;

  always #4 clk = ~clk;

  pinchg_irq_ctrl u_dut (
    .clk         (clk),
    .rst         (rst),
    .pins_i      (pins),
    .gie_i       (gie),
    .irq_ack_i   (ack),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_we_i    (we),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  // monitor: read data appears one edge after the address
  always @(posedge clk) rd_seen <= rd_strobe;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual=0x%02h expected=0x%02h", t, rdata, e);
      end
    end
  end

  task automatic bus_write(input logic [5:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [5:0] a, input logic [7:0] e, input string t);
    addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_strobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    bus_read(6'h10, 8'h00, "R1 mask reset");
    bus_read(6'h11, 8'h00, "R1 flag reset");
    bus_read(6'h12, 8'h00, "R1 ctrl reset");

    // R2 writable and reserved bits
    bus_write(6'h10, 8'hFF);
    bus_read(6'h10, 8'h0F, "R2 mask reserved bits");
    bus_write(6'h12, 8'hFF);
    bus_read(6'h12, 8'h01, "R2 ctrl reserved bits");
    bus_write(6'h12, 8'h00);
    bus_read(6'h12, 8'h00, "R2 ctrl cleared");
    bus_write(6'h10, 8'h05);
    bus_read(6'h10, 8'h05, "R2 mask pattern");

    // R4 unmasked pins
    pins[1] = 1'b1; idle(6);
    bus_read(6'h11, 8'h00, "R4 pin1 rise unmasked");
    pins[3] = 1'b1; idle(6);
    bus_read(6'h11, 8'h00, "R4 pin3 rise unmasked");
    pins[1] = 1'b0; idle(6);
    bus_read(6'h11, 8'h00, "R4 pin1 fall unmasked");

    // R3 rising edge, R5 gated by group enable, R7 clears
    pins[0] = 1'b1; idle(6);
    bus_read(6'h11, 8'h01, "R3 pin0 rise sets flag");
    gie = 1'b1; idle(2);
    chk_irq(1'b0, "R5 group enable clear");
    gie = 1'b0;
    bus_write(6'h11, 8'hFE);
    bus_read(6'h11, 8'h01, "R7 write zero keeps flag");
    bus_write(6'h11, 8'h01);
    bus_read(6'h11, 8'h00, "R7 write one clears flag");

    // R3 falling edge, R5 gating, R6 acknowledge
    pins[0] = 1'b0; idle(6);
    bus_read(6'h11, 8'h01, "R3 pin0 fall sets flag");
    bus_write(6'h12, 8'h01); idle(2);
    chk_irq(1'b0, "R5 global enable clear");
    gie = 1'b1; idle(1);
    chk_irq(1'b1, "R5 all terms set");
    pulse_ack(); idle(1);
    chk_irq(1'b0, "R6 irq drops after ack");
    bus_read(6'h11, 8'h00, "R6 ack clears flag");

    // R9 unmapped addresses
    bus_read(6'h13, 8'h00, "R9 read 0x13");
    bus_read(6'h0F, 8'h00, "R9 read 0x0F");
    gie = 1'b0;
    pins[2] = 1'b1; idle(6);
    bus_write(6'h13, 8'hFF);
    bus_write(6'h0F, 8'hFF);
    bus_write(6'h00, 8'h01);
    bus_read(6'h10, 8'h05, "R9 mask unchanged");
    bus_read(6'h12, 8'h01, "R9 ctrl unchanged");
    bus_read(6'h11, 8'h01, "R9 flag unchanged");
    bus_write(6'h11, 8'h01);
    bus_read(6'h11, 8'h00, "R9 flag cleared after test");

    // R10 latency: pin change between edges, irq after the fourth edge
    gie = 1'b1; idle(2);
    pins[2] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_irq(1'b0, "R10 irq not yet after third edge");
    @(posedge clk);
    @(negedge clk);
    chk_irq(1'b1, "R10 irq after fourth edge");

    // R8 set beats write-one clear (flag is 1 here)
    pins[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    bus_write(6'h11, 8'h01);
    bus_read(6'h11, 8'h01, "R8 set wins over write clear");

    // R8 set beats acknowledge
    pins[0] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    pulse_ack();
    bus_read(6'h11, 8'h01, "R8 set wins over ack");
    idle(1);
    chk_irq(1'b1, "R8 irq held");

    bus_write(6'h11, 8'h01);
    bus_read(6'h11, 8'h00, "R7 final clear");
    idle(2);
    chk_irq(1'b0, "R5 irq low after clear");

    idle(2);
    summary();
  end

endmodule